// File: doc/BRIEF.md
# Synchronous Serial Port with Slave Select

This block is a full-duplex, clock-synchronous shift port that moves 8-bit frames least significant bit first. One configuration bit picks its role. As a master it makes the serial clock itself from a programmable divider of the system clock, and it drives both the clock and the transmit line. As a slave it shifts on edges of an external clock. In both roles a new bit is launched on the falling serial edge and the incoming bit is sampled on the rising edge. The serial clock rests high between frames.

A select-enable bit turns on the select pin. A master with select enabled treats a low select level as a sign that another master has taken the bus. That sets a sticky fault flag, drops any frame in progress, and releases its clock and data output enables. The flag stays set until software clears it, and the clear only takes effect while select is high. A slave with select enabled uses clock edges only while select is low, and drives its data output only then. The select and clock inputs pass through two-flop synchronizers, and edges are found on the synchronized clock. The interrupt line pulses either when a frame completes or when a transmit byte is loaded, as chosen by a source bit.

Top module: `sync_serial_port`

## Requirements
- R1: As master, `tx_data` leaves on `ser_out` least significant bit first. Each bit is launched on a falling `sclk_o` edge and `ser_in` is sampled on the following rising edge. With `ser_out` looped back to `ser_in`, the received byte equals the sent byte.
- R2: `sclk_o` is high while the master is idle and after reset. During a frame, each low and each high phase lasts `cfg_half` system clocks, and a `cfg_half` of 0 acts as 1.
- R3: Each completed frame gives exactly one one-cycle `tx_done` pulse, and `rx_data` holds the received byte in that cycle. An abandoned frame gives no pulse.
- R4: With `cfg_sel_en` = 0, a low `sel_i` has no effect in master mode: frames complete and `mode_err` stays 0.
- R5: In master mode with `cfg_sel_en` = 1, a low `sel_i` sets `mode_err`, drives `sclk_oe` and `ser_out_oe` to 0, abandons the frame in progress and clears `busy`.
- R6: `mode_err` is sticky. A pulse on `err_clr` clears it only while the synchronized `sel_i` is high. Once it is cleared, `sclk_oe` and `ser_out_oe` return to 1.
- R7: While `mode_err` is 1, `tx_start` does not start a master frame.
- R8: In slave mode (`cfg_master` = 0), `sclk_oe` is 0. With `cfg_sel_en` = 1 and `sel_i` low, the port shifts on `sclk_i` edges, sends the loaded byte LSB first on `ser_out`, and receives from `ser_in`.
- R9: In slave mode with `cfg_sel_en` = 1 and `sel_i` high, `sclk_i` edges are ignored and the shift state is unchanged. `ser_out_oe` is 0.
- R10: With `cfg_irq_src` = 1, `irq` pulses together with `tx_done`. With `cfg_irq_src` = 0, `irq` pulses in the cycle after a transmit byte is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_master | input | 1 | 1 = master role, 0 = slave role |
| cfg_sel_en | input | 1 | Enables the select pin |
| cfg_irq_src | input | 1 | 1 = irq on frame completion, 0 = irq on byte load |
| cfg_half | input | DIV_W | Serial clock half period in system clocks |
| err_clr | input | 1 | Request to clear the fault flag |
| tx_start | input | 1 | Load `tx_data` (and start a frame as master) |
| tx_data | input | FRAME_BITS | Byte to transmit |
| rx_data | output | FRAME_BITS | Last byte received |
| tx_done | output | 1 | Frame-complete pulse |
| irq | output | 1 | Interrupt pulse |
| busy | output | 1 | Frame in progress |
| mode_err | output | 1 | Sticky mode fault flag |
| sclk_i | input | 1 | Serial clock input (slave) |
| sclk_o | output | 1 | Serial clock output (master) |
| sclk_oe | output | 1 | Serial clock output enable |
| sel_i | input | 1 | Select input |
| ser_in | input | 1 | Serial data input |
| ser_out | output | 1 | Serial data output |
| ser_out_oe | output | 1 | Serial data output enable |

## Verification
A clear request and a low select level can arrive in the same cycle, and the low select must win. The bench pulses `err_clr` while `sel_i` is still low after a fault, checks that `mode_err` stays set, and only then raises select and clears. A fault can also land in the middle of a frame. The bench lowers select partway through a master frame and judges it at the ports: the enables drop, `busy` clears, and the scoreboard sees no completion pulse for the abandoned byte.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int FRAME_BITS_DEF = 8;
  localparam int DIV_W_DEF      = 8;
  localparam int SYNC_DEPTH_DEF = 2;

  typedef enum logic {
    ROLE_SLAVE  = 1'b0,
    ROLE_MASTER = 1'b1
  } role_e;
endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
  parameter int              WIDTH   = 2,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= RST_VAL;
        else        stg_q[s] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= RST_VAL;
        else        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             sclk_q,
  output logic             fall_stb,
  output logic             rise_stb
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] half_eff;
  logic             sclk_d;
  logic             wrap;

  assign half_eff = (half == '0) ? DIV_W'(1) : half;
  assign wrap     = run && (cnt_q == half_eff - DIV_W'(1));
  assign fall_stb = wrap & sclk_q;
  assign rise_stb = wrap & ~sclk_q;

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!run) begin
      cnt_d  = '0;
      sclk_d = 1'b1;
    end else if (wrap) begin
      cnt_d  = '0;
      sclk_d = ~sclk_q;
    end else begin
      cnt_d  = cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int BITS = 8,
  localparam int CW  = (BITS > 1) ? $clog2(BITS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [BITS-1:0] load_data,
  input  logic            fall,
  input  logic            rise,
  input  logic            abort,
  input  logic            ser_in,
  output logic            out_bit,
  output logic            last_rise,
  output logic [BITS-1:0] rx_word,
  output logic [CW-1:0]   bit_cnt
);
  logic [BITS-1:0] shreg_q, shreg_d;
  logic [BITS-1:0] rx_d;
  logic [CW-1:0]   cnt_d;
  logic            out_d;
  logic            at_last;

  assign at_last   = (bit_cnt == CW'(BITS - 1));
  assign last_rise = rise & ~abort & at_last;

  always_comb begin
    shreg_d = shreg_q;
    rx_d    = rx_word;
    cnt_d   = bit_cnt;
    out_d   = out_bit;
    if (abort) begin
      cnt_d = '0;
    end else if (load) begin
      shreg_d = load_data;
      cnt_d   = '0;
    end else begin
      if (fall) begin
        out_d = shreg_q[0];
      end
      if (rise) begin
        shreg_d = {ser_in, shreg_q[BITS-1:1]};
        if (at_last) begin
          cnt_d = '0;
          rx_d  = {ser_in, shreg_q[BITS-1:1]};
        end else begin
          cnt_d = bit_cnt + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      rx_word <= '0;
      bit_cnt <= '0;
      out_bit <= 1'b1;
    end else begin
      shreg_q <= shreg_d;
      rx_word <= rx_d;
      bit_cnt <= cnt_d;
      out_bit <= out_d;
    end
  end
endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic master,
  input  logic sel_en,
  input  logic sel_s,
  input  logic err_clr,
  input  logic tx_start,
  input  logic last_rise,
  output logic err_q,
  output logic busy_q,
  output logic fault,
  output logic start_ok
);
  logic err_d, busy_d;

  assign fault    = master & sel_en & ~sel_s;
  assign start_ok = master & tx_start & ~busy_q & ~err_q & ~fault;

  always_comb begin
    err_d = err_q;
    if (fault)                err_d = 1'b1;
    else if (err_clr & sel_s) err_d = 1'b0;
  end

  always_comb begin
    busy_d = busy_q;
    if (fault | ~master) busy_d = 1'b0;
    else if (start_ok)   busy_d = 1'b1;
    else if (last_rise)  busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      err_q  <= err_d;
      busy_q <= busy_d;
    end
  end
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import ssp_pkg::*;
#(
  parameter int FRAME_BITS = FRAME_BITS_DEF,
  parameter int DIV_W      = DIV_W_DEF,
  parameter int SYNC_DEPTH = SYNC_DEPTH_DEF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_master,
  input  logic                  cfg_sel_en,
  input  logic                  cfg_irq_src,
  input  logic [DIV_W-1:0]      cfg_half,
  input  logic                  err_clr,
  input  logic                  tx_start,
  input  logic [FRAME_BITS-1:0] tx_data,
  output logic [FRAME_BITS-1:0] rx_data,
  output logic                  tx_done,
  output logic                  irq,
  output logic                  busy,
  output logic                  mode_err,
  input  logic                  sclk_i,
  output logic                  sclk_o,
  output logic                  sclk_oe,
  input  logic                  sel_i,
  input  logic                  ser_in,
  output logic                  ser_out,
  output logic                  ser_out_oe
);
  localparam int CNT_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;

  role_e            role;
  logic             sel_s, sclk_s, sclk_prev_q;
  logic             slave_act, s_fall, s_rise;
  logic             m_run, m_sclk, m_fall, m_rise;
  logic             fall, rise;
  logic             err_q, busy_q, fault, start_ok;
  logic             slave_load, load;
  logic             last_rise;
  logic             out_bit;
  logic [CNT_W-1:0] bit_cnt;
  logic             tx_done_d, irq_d;

  assign role = cfg_master ? ROLE_MASTER : ROLE_SLAVE;

  ssp_sync #(
    .WIDTH   (2),
    .STAGES  (SYNC_DEPTH),
    .RST_VAL (2'b11)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sel_i, sclk_i}),
    .q     ({sel_s, sclk_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev_q <= 1'b1;
    else        sclk_prev_q <= sclk_s;
  end

  assign slave_act = (role == ROLE_SLAVE) & (~cfg_sel_en | ~sel_s);
  assign s_fall    = slave_act & sclk_prev_q & ~sclk_s;
  assign s_rise    = slave_act & ~sclk_prev_q & sclk_s;

  assign m_run = busy_q & (role == ROLE_MASTER);

  ssp_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (m_run),
    .half     (cfg_half),
    .sclk_q   (m_sclk),
    .fall_stb (m_fall),
    .rise_stb (m_rise)
  );

  assign fall = (role == ROLE_MASTER) ? m_fall : s_fall;
  assign rise = (role == ROLE_MASTER) ? m_rise : s_rise;

  ssp_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .master    (role == ROLE_MASTER),
    .sel_en    (cfg_sel_en),
    .sel_s     (sel_s),
    .err_clr   (err_clr),
    .tx_start  (tx_start),
    .last_rise (last_rise),
    .err_q     (err_q),
    .busy_q    (busy_q),
    .fault     (fault),
    .start_ok  (start_ok)
  );

  assign slave_load = (role == ROLE_SLAVE) & tx_start & (bit_cnt == '0) & ~s_fall & ~s_rise;
  assign load       = start_ok | slave_load;

  ssp_shifter #(.BITS(FRAME_BITS)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_data (tx_data),
    .fall      (fall),
    .rise      (rise),
    .abort     (fault),
    .ser_in    (ser_in),
    .out_bit   (out_bit),
    .last_rise (last_rise),
    .rx_word   (rx_data),
    .bit_cnt   (bit_cnt)
  );

  assign tx_done_d = last_rise & ~fault;
  assign irq_d     = cfg_irq_src ? tx_done_d : load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_done <= 1'b0;
      irq     <= 1'b0;
    end else begin
      tx_done <= tx_done_d;
      irq     <= irq_d;
    end
  end

  assign mode_err   = err_q;
  assign busy       = (role == ROLE_MASTER) ? busy_q : (bit_cnt != '0);
  assign sclk_o     = (role == ROLE_MASTER) ? (m_sclk | ~busy_q) : 1'b1;
  assign sclk_oe    = (role == ROLE_MASTER) & ~err_q;
  assign ser_out    = out_bit;
  assign ser_out_oe = (role == ROLE_MASTER) ? ~err_q : (~cfg_sel_en | ~sel_s);
endmodule

// File: rtl/ssp_chk.sv
module ssp_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_master,
  input logic             cfg_sel_en,
  input logic             sel_s,
  input logic             mode_err,
  input logic             sclk_o,
  input logic             sclk_oe,
  input logic             ser_out_oe,
  input logic             tx_done,
  input logic             busy,
  input logic [CNT_W-1:0] bit_cnt
);
  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err && !sel_s |=> mode_err);

  // R5
  fault_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_master && mode_err |-> !sclk_oe && !ser_out_oe);

  // R5
  fault_abandon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_master && cfg_sel_en && !sel_s |=> !busy);

  // R2
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_master && !busy |-> sclk_o);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);

  // R9
  slave_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_master && cfg_sel_en && sel_s |=> $stable(bit_cnt));
endmodule

bind sync_serial_port ssp_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_master (cfg_master),
  .cfg_sel_en (cfg_sel_en),
  .sel_s      (sel_s),
  .mode_err   (mode_err),
  .sclk_o     (sclk_o),
  .sclk_oe    (sclk_oe),
  .ser_out_oe (ser_out_oe),
  .tx_done    (tx_done),
  .busy       (busy),
  .bit_cnt    (bit_cnt)
);

// File: tb/sync_serial_port_tb.sv
module sync_serial_port_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_master, cfg_sel_en, cfg_irq_src;
  logic [7:0] cfg_half;
  logic       err_clr, tx_start;
  logic [7:0] tx_data;
  logic [7:0] rx_data;
  logic       tx_done, irq, busy, mode_err;
  logic       sclk_i, sclk_o, sclk_oe, sel_i, ser_in, ser_out, ser_out_oe;
  logic       slv_din;

  int n_chk = 0;
  int n_err = 0;
  int done_cnt = 0;
  int low_run = 0;
  int last_low = 0;
  logic [7:0] m_cap = 8'h00;
  logic [7:0] exp_q[$];
  bit finished = 1'b0;

  always #2 clk = ~clk;

  assign ser_in = cfg_master ? ser_out : slv_din;

  sync_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_sel_en(cfg_sel_en),
    .cfg_irq_src(cfg_irq_src), .cfg_half(cfg_half), .err_clr(err_clr),
    .tx_start(tx_start), .tx_data(tx_data), .rx_data(rx_data), .tx_done(tx_done),
    .irq(irq), .busy(busy), .mode_err(mode_err), .sclk_i(sclk_i), .sclk_o(sclk_o),
    .sclk_oe(sclk_oe), .sel_i(sel_i), .ser_in(ser_in), .ser_out(ser_out),
    .ser_out_oe(ser_out_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor (R3): each completion pops one expected byte
  always @(negedge clk) begin
    if (rst_n === 1'b1 && tx_done === 1'b1) begin
      done_cnt++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected tx_done", rx_data, 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rx_data == e, "R3 rx_data at tx_done", rx_data, e);
      end
    end
  end

  // serial clock low-phase length monitor (R2)
  always @(negedge clk) begin
    if (sclk_o === 1'b0) low_run++;
    else begin
      if (low_run != 0) last_low = low_run;
      low_run = 0;
    end
  end

  // line capture on rising master clock (R1)
  always @(posedge sclk_o) begin
    if (cfg_master === 1'b1) m_cap <= {ser_out, m_cap[7:1]};
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
  endtask

  task automatic pulse_start(input logic [7:0] b);
    tx_data  = b;
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
  endtask

  task automatic master_frame(input logic [7:0] b);
    int eff;
    eff = (cfg_half == 0) ? 1 : int'(cfg_half);
    exp_q.push_back(b);
    pulse_start(b);
    wait_idle();
    cyc(3);
    chk(m_cap == b, "R1 LSB-first line bits", m_cap, b);
    chk(last_low == eff, "R2 low phase length", last_low, eff);
  endtask

  task automatic slave_frame(input logic [7:0] din, output logic [7:0] seen);
    seen = 8'h00;
    for (int i = 0; i < 8; i++) begin
      sclk_i  = 1'b0;
      slv_din = din[i];
      cyc(8);
      seen    = {ser_out, seen[7:1]};
      sclk_i  = 1'b1;
      cyc(8);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] seen;
    int d0;
    rst_n = 1'b0; cfg_master = 1'b1; cfg_sel_en = 1'b0; cfg_irq_src = 1'b1;
    cfg_half = 8'd2; err_clr = 1'b0; tx_start = 1'b0; tx_data = 8'h00;
    sclk_i = 1'b1; sel_i = 1'b1; slv_din = 1'b0;
    cyc(5);
    rst_n = 1'b1;
    cyc(2);
    // R2 reset state
    chk(sclk_o == 1'b1, "R2 reset sclk_o", sclk_o, 1);
    chk(mode_err == 1'b0, "R6 reset mode_err", mode_err, 0);
    chk(busy == 1'b0, "R3 reset busy", busy, 0);
    chk(sclk_oe == 1'b1, "R5 reset sclk_oe", sclk_oe, 1);

    // R1 R2 master loopback over several patterns and dividers
    master_frame(8'hA5);
    cfg_half = 8'd3; master_frame(8'h3C);
    cfg_half = 8'd0; master_frame(8'h00);
    cfg_half = 8'd2; master_frame(8'hFF);

    // R10 irq source select
    cfg_irq_src = 1'b0;
    exp_q.push_back(8'h81);
    pulse_start(8'h81);
    chk(irq == 1'b1, "R10 irq on load (src=0)", irq, 1);
    wait_idle(); cyc(3);
    cfg_irq_src = 1'b1;
    exp_q.push_back(8'h18);
    pulse_start(8'h18);
    chk(irq == 1'b0, "R10 no irq on load (src=1)", irq, 0);
    for (int i = 0; i < 200; i++) begin
      if (tx_done) break;
      @(negedge clk);
    end
    chk(irq == tx_done && tx_done == 1'b1, "R10 irq with tx_done", irq, 1);
    wait_idle(); cyc(3);

    // R4 select disabled: low select ignored
    sel_i = 1'b0; cyc(4);
    master_frame(8'h5A);
    chk(mode_err == 1'b0, "R4 no fault with select disabled", mode_err, 0);
    sel_i = 1'b1; cyc(4);

    // R5 mode fault mid-frame
    cfg_sel_en = 1'b1; cyc(2);
    d0 = done_cnt;
    pulse_start(8'hC3);
    cyc(6);
    sel_i = 1'b0;
    cyc(5);
    chk(mode_err == 1'b1, "R5 fault sets mode_err", mode_err, 1);
    chk(sclk_oe == 1'b0, "R5 sclk_oe released", sclk_oe, 0);
    chk(ser_out_oe == 1'b0, "R5 ser_out_oe released", ser_out_oe, 0);
    chk(busy == 1'b0, "R5 frame abandoned", busy, 0);
    cyc(40);
    chk(done_cnt == d0, "R5 no tx_done for abandoned frame", done_cnt, d0);

    // R6 clear while select low is refused (same-cycle case)
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    cyc(3);
    chk(mode_err == 1'b1, "R6 clear refused while select low", mode_err, 1);
    sel_i = 1'b1; cyc(5);
    chk(mode_err == 1'b1, "R6 flag sticky after select high", mode_err, 1);

    // R7 start refused while flag set
    pulse_start(8'h77);
    cyc(3);
    chk(busy == 1'b0, "R7 start refused with mode_err", busy, 0);

    // R6 clear accepted
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    cyc(2);
    chk(mode_err == 1'b0, "R6 clear accepted", mode_err, 0);
    chk(sclk_oe == 1'b1 && ser_out_oe == 1'b1, "R6 outputs driven again",
        {sclk_oe, ser_out_oe}, 3);
    master_frame(8'h96);

    // R9 slave with select high ignores the clock
    cfg_master = 1'b0; cyc(4);
    chk(sclk_oe == 1'b0, "R8 slave sclk_oe", sclk_oe, 0);
    chk(ser_out_oe == 1'b0, "R9 slave output released", ser_out_oe, 0);
    pulse_start(8'h6B);
    d0 = done_cnt;
    slave_frame(8'hFF, seen);
    cyc(6);
    chk(busy == 1'b0, "R9 edges ignored, no shift", busy, 0);
    chk(done_cnt == d0, "R9 no completion while deselected", done_cnt, d0);

    // R8 slave exchange with select low
    sel_i = 1'b0; cyc(4);
    chk(ser_out_oe == 1'b1, "R8 slave drives when selected", ser_out_oe, 1);
    exp_q.push_back(8'hD2);
    slave_frame(8'hD2, seen);
    cyc(6);
    chk(seen == 8'h6B, "R8 slave sends loaded byte LSB first", seen, 8'h6B);
    chk(done_cnt == d0 + 1, "R8 slave frame completes", done_cnt, d0 + 1);

    cyc(4);
    chk(exp_q.size() == 0, "R3 all expected frames completed", exp_q.size(), 0);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule